// File: doc/BRIEF.md
# Stall-While-Write Flash Read Arbiter

This block sits between a simple system-bus read port and a flash array split into two banks. Either bank may be busy with a program or erase job when a read arrives. The arbiter accepts one read at a time and registers its address. It then either sends the read straight to the addressed bank or holds it until that bank is free. After the hold it replays the registered address to the bank. Bus ready stays low for the whole time the read is in flight.

Each bank has a 3-bit policy code that sets what a read hitting that busy bank also does. It may do nothing more, set a sticky stall notice, force the bank's abort line so the program or erase job ends, or force abort and set a sticky abort notice. The four sticky notices share one byte-wide flag view. Software clears a notice by writing a one to its bit. An interrupt request is high whenever any notice is set.

Top module: `flash_rww_arb`

## Requirements
- R1: After reset, ready is 1, both bank read enables are 0, both abort outputs are 0, the flag byte is 0x00 and irq_req is 0.
- R2: A read is accepted in a cycle where ready and req_valid are both high. Address bit AW-1 selects the bank (0 selects bank 0). If that bank is not busy at acceptance, then in the next cycle rd_en for that bank alone is high and rd_addr equals the accepted address. No flag changes and no abort rises, whatever the bank's policy code.
- R3: Ready is low from the cycle after acceptance until the read ends. The read ends at the first clock edge where the selected bank's rvalid is high while its read enable or the wait that follows it is active. Ready is high again in the cycle after that edge.
- R4: If the selected bank is busy at acceptance, the read is held and its rd_en stays 0 while the bank stays busy. In the cycle after the first edge at which busy is low, rd_en for that bank is high and rd_addr equals the accepted address.
- R5: Policy codes 0b111 and 0b000 to 0b011 only hold the read. They set no flag and raise no abort.
- R6: Policy code 0b110 holds the read and sets that bank's stall flag in the cycle after acceptance. It raises no abort.
- R7: Policy code 0b101 holds the read and raises that bank's abort in the cycle after acceptance. It sets no flag.
- R8: Policy code 0b100 holds the read, raises that bank's abort and sets that bank's termination flag, all in the cycle after acceptance.
- R9: Once high, a bank's abort stays high until a clock edge at which that bank's done input is high. It is low in the cycle after that edge.
- R10: Flag byte layout: bit 7 is bank 0 termination, bit 6 is bank 0 stall, bit 5 is bank 1 termination, bit 4 is bank 1 stall. Bits 3:0 always read 0.
- R11: irq_req is high exactly when at least one of flag bits 7:4 is set.
- R12: Flags are sticky. A flag bit is cleared only by a clock edge with irq_wr_en high and a 1 in the same bit of irq_wr_data. Writing 0 to a bit leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW | Read address, bit AW-1 selects the bank |
| mode_cfg | input | 6 | Policy codes, bank 0 in bits 2:0, bank 1 in bits 5:3 |
| bank_busy | input | 2 | Per-bank program or erase in progress |
| bank_done | input | 2 | Per-bank program or erase finished |
| bank_rvalid | input | 2 | Per-bank read data valid |
| irq_wr_en | input | 1 | Flag clear write strobe |
| irq_wr_data | input | 8 | Write-one-to-clear mask, same layout as the flag byte |
| rd_en | output | 2 | Per-bank read enable |
| rd_addr | output | AW | Registered read address |
| abort | output | 2 | Per-bank program or erase abort |
| ready | output | 1 | Bus ready, low while a read is in flight |
| irq_flags | output | 8 | Sticky notification flags |
| irq_req | output | 1 | OR of all notification flags |

## Verification
A wrong sequencer state shows up at once as a wrong ready level or a wrong rd_en one cycle after acceptance. A read stuck in the hold state shows up as rd_en never rising after busy drops. A wrong policy decode shows up as an abort or flag bit one cycle after a read hits a busy bank. Bank swaps show up as the wrong flag bit or rd_en bit. An abort register that clears early or stays high too long is visible in the cycles around the done pulse. A flag that clears on its own is visible after the read completes and before any clear write.

// File: rtl/swr_pkg.sv
package swr_pkg;

  localparam int NUM_BANKS = 2;
  localparam int MODE_W    = 3;
  localparam int FLAG_W    = 8;
  localparam int FLAG_LSB  = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic kill;       // force abort of program/erase
    logic note_hold;  // stall notification
    logic note_kill;  // termination notification
  } policy_t;

  function automatic policy_t decode_policy(input logic [MODE_W-1:0] code);
    policy_t p;
    p = '0;
    case (code)
      3'b110:  p.note_hold = 1'b1;
      3'b101:  p.kill      = 1'b1;
      3'b100: begin
        p.kill      = 1'b1;
        p.note_kill = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/swr_bank_ctl.sv
module swr_bank_ctl
  import swr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              hit,
  input  logic              done,
  input  logic              clr_kill_note,
  input  logic              clr_hold_note,
  output logic              abort_o,
  output logic              kill_note_o,
  output logic              hold_note_o
);

  policy_t pol;
  logic    abort_q, abort_d;
  logic    kill_q,  kill_d;
  logic    hold_q,  hold_d;

  always_comb begin
    pol     = decode_policy(mode);
    abort_d = abort_q;
    kill_d  = kill_q;
    hold_d  = hold_q;
    if (done)          abort_d = 1'b0;
    if (hit && pol.kill) abort_d = 1'b1;
    if (clr_kill_note) kill_d = 1'b0;
    if (hit && pol.note_kill) kill_d = 1'b1;
    if (clr_hold_note) hold_d = 1'b0;
    if (hit && pol.note_hold) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      kill_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      abort_q <= abort_d;
      kill_q  <= kill_d;
      hold_q  <= hold_d;
    end
  end

  assign abort_o     = abort_q;
  assign kill_note_o = kill_q;
  assign hold_note_o = hold_q;

endmodule

// File: rtl/swr_seq.sv
module swr_seq
  import swr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic [NUM_BANKS-1:0] bank_rvalid,
  output logic                 ready,
  output logic [NUM_BANKS-1:0] issue,
  output logic [NUM_BANKS-1:0] hold_hit,
  output logic [AW-1:0]        addr_o
);

  localparam int BANK_BIT = AW - 1;

  seq_state_t  state_q, state_d;
  logic [AW-1:0] addr_q;
  logic        bank_q;
  logic        req_bank;
  logic        accept;
  logic        tgt_busy;

  assign req_bank = req_addr[BANK_BIT];
  assign accept   = (state_q == SEQ_IDLE) && req_valid;
  assign tgt_busy = bank_busy[req_bank];

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE:  if (accept) state_d = tgt_busy ? SEQ_HOLD : SEQ_ISSUE;
      SEQ_ISSUE: state_d = bank_rvalid[bank_q] ? SEQ_IDLE : SEQ_WAIT;
      SEQ_WAIT:  if (bank_rvalid[bank_q]) state_d = SEQ_IDLE;
      SEQ_HOLD:  if (!bank_busy[bank_q]) state_d = SEQ_ISSUE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bank_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      bank_q <= req_bank;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign issue[b]    = (state_q == SEQ_ISSUE) && (bank_q == b[0]);
    assign hold_hit[b] = accept && tgt_busy && (req_bank == b[0]);
  end

  assign ready  = (state_q == SEQ_IDLE);
  assign addr_o = addr_q;

endmodule

// File: rtl/flash_rww_arb.sv
module flash_rww_arb
  import swr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [AW-1:0]                 req_addr,
  input  logic [NUM_BANKS*MODE_W-1:0]   mode_cfg,
  input  logic [NUM_BANKS-1:0]          bank_busy,
  input  logic [NUM_BANKS-1:0]          bank_done,
  input  logic [NUM_BANKS-1:0]          bank_rvalid,
  input  logic                          irq_wr_en,
  input  logic [FLAG_W-1:0]             irq_wr_data,
  output logic [NUM_BANKS-1:0]          rd_en,
  output logic [AW-1:0]                 rd_addr,
  output logic [NUM_BANKS-1:0]          abort,
  output logic                          ready,
  output logic [FLAG_W-1:0]             irq_flags,
  output logic                          irq_req
);

  logic [NUM_BANKS-1:0] hold_hit;
  logic [NUM_BANKS-1:0] kill_note;
  logic [NUM_BANKS-1:0] hold_note;
  logic [NUM_BANKS-1:0] clr_kill;
  logic [NUM_BANKS-1:0] clr_hold;

  swr_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .bank_busy   (bank_busy),
    .bank_rvalid (bank_rvalid),
    .ready       (ready),
    .issue       (rd_en),
    .hold_hit    (hold_hit),
    .addr_o      (rd_addr)
  );

  // Bank b: termination at bit 7-2b, stall at bit 6-2b.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ctl
    localparam int KBIT = FLAG_W - 1 - 2*b;
    localparam int HBIT = FLAG_W - 2 - 2*b;

    assign clr_kill[b] = irq_wr_en && irq_wr_data[KBIT];
    assign clr_hold[b] = irq_wr_en && irq_wr_data[HBIT];

    swr_bank_ctl u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode          (mode_cfg[b*MODE_W +: MODE_W]),
      .hit           (hold_hit[b]),
      .done          (bank_done[b]),
      .clr_kill_note (clr_kill[b]),
      .clr_hold_note (clr_hold[b]),
      .abort_o       (abort[b]),
      .kill_note_o   (kill_note[b]),
      .hold_note_o   (hold_note[b])
    );

    assign irq_flags[KBIT] = kill_note[b];
    assign irq_flags[HBIT] = hold_note[b];
  end

  assign irq_flags[FLAG_LSB-1:0] = '0;
  assign irq_req = |{kill_note, hold_note};

endmodule

// File: rtl/swr_chk.sv
module swr_chk
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    bank_busy,
  input logic [1:0]    bank_done,
  input logic          irq_wr_en,
  input logic [7:0]    irq_wr_data,
  input logic [1:0]    rd_en,
  input logic [1:0]    abort,
  input logic          ready,
  input logic [7:0]    irq_flags,
  input logic          irq_req
);

  AST_RDEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en)); // R2

  AST_READY_LOW_ON_RDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_en) |-> !ready); // R3

  AST_FREE_READ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid && !bank_busy[req_addr[AW-1]] && !irq_wr_en) |=> $stable(irq_flags)); // R2

  AST_ABORT_HOLD_B0: assert property (@(posedge clk) disable iff (!rst_n)
    (abort[0] && !bank_done[0]) |=> abort[0]); // R9

  AST_ABORT_HOLD_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (abort[1] && !bank_done[1]) |=> abort[1]); // R9

  AST_ABORT_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|abort) |-> !ready); // R7

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags[3:0] == 4'h0); // R10

  AST_REQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(!irq_req) && (irq_flags[7:4] != 4'h0)); // R11

  for (genvar i = 4; i < 8; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flags[i] && !(irq_wr_en && irq_wr_data[i])) |=> irq_flags[i]); // R12
  end

endmodule

bind flash_rww_arb swr_chk #(.AW(AW)) u_swr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .bank_busy   (bank_busy),
  .bank_done   (bank_done),
  .irq_wr_en   (irq_wr_en),
  .irq_wr_data (irq_wr_data),
  .rd_en       (rd_en),
  .abort       (abort),
  .ready       (ready),
  .irq_flags   (irq_flags),
  .irq_req     (irq_req)
);

// File: tb/flash_rww_arb_bench.sv
module flash_rww_arb_bench;

  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [5:0]    mode_cfg;
  logic [1:0]    bank_busy;
  logic [1:0]    bank_done;
  logic [1:0]    bank_rvalid;
  logic          irq_wr_en;
  logic [7:0]    irq_wr_data;
  logic [1:0]    rd_en;
  logic [AW-1:0] rd_addr;
  logic [1:0]    abort;
  logic          ready;
  logic [7:0]    irq_flags;
  logic          irq_req;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  flash_rww_arb #(.AW(AW)) u_flash_rww_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .mode_cfg(mode_cfg), .bank_busy(bank_busy), .bank_done(bank_done),
    .bank_rvalid(bank_rvalid), .irq_wr_en(irq_wr_en), .irq_wr_data(irq_wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .abort(abort), .ready(ready),
    .irq_flags(irq_flags), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic set_mode(input int b, input logic [2:0] m);
    mode_cfg[b*3 +: 3] = m;
  endtask

  task automatic clear_all();
    @(negedge clk);
    irq_wr_en = 1'b1; irq_wr_data = 8'hF0;
    @(negedge clk);
    irq_wr_en = 1'b0; irq_wr_data = 8'h00;
  endtask

  task automatic t_reset();
    chk_eq("R1 ready", ready, 1);
    chk_eq("R1 rd_en", rd_en, 0);
    chk_eq("R1 abort", abort, 0);
    chk_eq("R1 flags", irq_flags, 0);
    chk_eq("R1 irq_req", irq_req, 0);
  endtask

  // Read to an idle bank, any policy code.
  task automatic t_free_read(input int b, input logic [2:0] m, input logic [14:0] lo);
    logic [AW-1:0] a;
    a = {b[0], lo};
    set_mode(b, m);
    bank_busy = 2'b00;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R2 rd_en onehot", rd_en, 2'b01 << b);
    chk_eq("R2 rd_addr", rd_addr, a);
    chk_eq("R3 ready low", ready, 0);
    chk_eq("R2 no abort", abort, 0);
    chk_eq("R2 no flags", irq_flags, 0);
    @(negedge clk);
    chk_eq("R3 ready low in wait", ready, 0);
    chk_eq("R2 rd_en single", rd_en, 0);
    bank_rvalid[b] = 1'b1;
    @(negedge clk);
    bank_rvalid = 2'b00;
    chk_eq("R3 ready back", ready, 1);
  endtask

  // Read to a busy bank under a given policy code.
  task automatic t_busy_read(input int b, input logic [2:0] m, input logic [14:0] lo, input string req);
    logic [AW-1:0] a;
    bit exp_kill, exp_hnote, exp_knote;
    logic [7:0] exp_flags;
    a = {b[0], lo};
    exp_kill  = (m == 3'b101) || (m == 3'b100);
    exp_hnote = (m == 3'b110);
    exp_knote = (m == 3'b100);
    exp_flags = 8'h00;
    if (exp_knote) exp_flags[7 - 2*b] = 1'b1;
    if (exp_hnote) exp_flags[6 - 2*b] = 1'b1;
    set_mode(b, m);
    bank_busy[b] = 1'b1;
    bank_done = 2'b00;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq({req, " R4 held"}, rd_en, 0);
    chk_eq({req, " R3 ready low"}, ready, 0);
    chk_eq({req, " abort"}, abort, exp_kill ? (2'b01 << b) : 2'b00);
    chk_eq({req, " R10 flags"}, irq_flags, exp_flags);
    chk_eq({req, " R11 irq_req"}, irq_req, exp_flags != 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_eq("R4 still held", rd_en, 0);
      chk_eq("R9 abort kept", abort[b], exp_kill);
    end
    bank_busy[b] = 1'b0; bank_done[b] = 1'b1;
    @(negedge clk);
    bank_done = 2'b00;
    chk_eq("R9 abort dropped", abort, 0);
    chk_eq("R4 replay rd_en", rd_en, 2'b01 << b);
    chk_eq("R4 replay addr", rd_addr, a);
    @(negedge clk);
    chk_eq("R3 ready low before data", ready, 0);
    bank_rvalid[b] = 1'b1;
    @(negedge clk);
    bank_rvalid = 2'b00;
    chk_eq("R3 ready after data", ready, 1);
    chk_eq("R12 flags kept after read", irq_flags, exp_flags);
    clear_all();
    chk_eq("R12 clear all", irq_flags, 0);
    chk_eq("R11 irq_req low", irq_req, 0);
  endtask

  // Sticky flags, partial clears, set beating clear.
  task automatic t_sticky();
    set_mode(0, 3'b110);
    bank_busy = 2'b01;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0040;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R12 stall flag set", irq_flags, 8'h40);
    irq_wr_en = 1'b1; irq_wr_data = 8'hBF;
    @(negedge clk);
    irq_wr_en = 1'b0;
    chk_eq("R12 zero-write keeps bit", irq_flags, 8'h40);
    irq_wr_en = 1'b1; irq_wr_data = 8'h40;
    @(negedge clk);
    irq_wr_en = 1'b0;
    chk_eq("R12 one-write clears bit", irq_flags, 8'h00);
    bank_busy = 2'b00;
    @(negedge clk);
    bank_rvalid = 2'b01;
    @(negedge clk);
    @(negedge clk);
    bank_rvalid = 2'b00;
    chk_eq("R3 idle", ready, 1);
    // Set and clear of bank1 stall in the same cycle.
    set_mode(1, 3'b110);
    bank_busy = 2'b10;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h8001;
    irq_wr_en = 1'b1; irq_wr_data = 8'h10;
    @(negedge clk);
    req_valid = 1'b0; irq_wr_en = 1'b0;
    chk_eq("R12 set wins", irq_flags, 8'h10);
    chk_eq("R11 irq_req", irq_req, 1);
    bank_busy = 2'b00;
    @(negedge clk);
    bank_rvalid = 2'b10;
    @(negedge clk);
    @(negedge clk);
    bank_rvalid = 2'b00;
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; mode_cfg = 6'b111111;
    bank_busy = 2'b00; bank_done = 2'b00; bank_rvalid = 2'b00;
    irq_wr_en = 1'b0; irq_wr_data = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_free_read(0, 3'b100, 15'h0123);
    t_free_read(1, 3'b110, 15'h7ABC);
    t_busy_read(0, 3'b111, 15'h0011, "R5 code7");
    t_busy_read(1, 3'b010, 15'h0022, "R5 code2");
    t_busy_read(0, 3'b110, 15'h0033, "R6 b0");
    t_busy_read(1, 3'b110, 15'h0044, "R6 b1");
    t_busy_read(0, 3'b101, 15'h0055, "R7 b0");
    t_busy_read(1, 3'b101, 15'h0066, "R7 b1");
    t_busy_read(0, 3'b100, 15'h0077, "R8 b0");
    t_busy_read(1, 3'b100, 15'h0088, "R8 b1");
    t_sticky();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule